// File: doc/BRIEF.md
# Self-Checking Memory Pattern Tester

This block exercises a memory through a simple controller user port and checks what comes back. After reset it writes a known pattern to every location of every bank. It then reads all locations back in the same order and compares each returned word, byte lane by byte lane, with the pattern it expects. The expected word is computed from the bank and address of each read, so the block keeps no copy of the written data. Only the bank and address of each outstanding read are queued, in a small FIFO.

Results appear on two kinds of active-low outputs. One pass bit per byte lane drops for a single cycle when that lane of a returned word is wrong. A sticky pass flag drops on the first wrong lane and stays low until reset. A done output reports the end of a pass. A parameter selects whether the test then stops or starts over with a fresh write pass.

Top module: `mem_pattern_tester`

## Requirements
- R1: While reset is held, and in the first cycle after it, every `lane_pass` bit is 1, `all_pass` is 1 and `test_done` is 0.
- R2: The write pass starts at bank 0, address 0. The address steps first and the bank steps when the address wraps, until every location of every bank is written. Every write has `cmd_write`=1 and all `cmd_be` bits at 1. No read is issued before the last write has been accepted.
- R3: The write data for bank b, address a has, in byte lane i (bits 8i+7..8i), the value (a mod 256) XOR ((0x5A + 0x3B·b) mod 256) XOR ((0x11·i) mod 256).
- R4: The read pass visits the locations in the same order as the write pass, with `cmd_write`=0 and all `cmd_be` bits at 0.
- R5: A command is accepted on a cycle where `cmd_valid` and `cmd_ready` are both 1. While `cmd_valid`=1 and `cmd_ready`=0, the next cycle still shows `cmd_valid`=1 with the same `cmd_write`, `cmd_bank`, `cmd_addr` and `cmd_wdata`.
- R6: Accepted reads whose data has not yet returned never exceed FIFO_DEPTH. While FIFO_DEPTH reads are outstanding, `cmd_valid` is 0.
- R7: Read data returns in issue order, one word per cycle with `rd_valid`=1. In the cycle after such a word, `lane_pass[i]` is 0 exactly when byte lane i differs from the R3 pattern of the matching read.
- R8: In a cycle after one where `rd_valid` was 0, every `lane_pass` bit is 1, including throughout the write pass.
- R9: `all_pass` goes to 0 in the same cycle as the first 0 on any `lane_pass` bit. It stays 0 until reset.
- R10: `test_done` goes to 1 one cycle after the `lane_pass` result of the last read appears.
- R11: With LOOP=0, `test_done` stays 1 and `cmd_valid` stays 0 after a pass ends. With LOOP=1, `test_done` is 1 for one cycle. The next cycle shows a write to bank 0, address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | output | 1 | Command request |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Location within the bank |
| cmd_wdata | output | DATA_W | Write data |
| cmd_be | output | DATA_W/8 | Byte enables |
| cmd_ready | input | 1 | Controller accepts the command |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | DATA_W | Returned read data |
| lane_pass | output | DATA_W/8 | Per-lane result, 0 for one cycle on a mismatch |
| all_pass | output | 1 | Sticky result, 0 after any mismatch |
| test_done | output | 1 | Pass complete |

## Verification
The hardest situation to reach is a full tag FIFO with its head pop and a new read accepted in the same window. The stall rule and the order check only mean something when reads stack up against delayed responses. The controller model in the bench accepts commands about 70% of the time but returns data only about 30% of the time, so outstanding reads repeatedly reach FIFO_DEPTH. Corruption is injected into chosen returned words, covering one lane, two lanes and the top lane. This pins down both the one-cycle lane pulses and the moment the sticky flag falls. A second, small instance built with LOOP=1 runs two full passes to check the restart.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

    typedef enum logic [1:0] {
        PH_WRITE = 2'd0,
        PH_READ  = 2'd1,
        PH_DRAIN = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic fire;
        logic last;
    } step_t;

    localparam logic [7:0] SEED_BASE = 8'h5A;
    localparam logic [7:0] SEED_STEP = 8'h3B;
    localparam logic [7:0] LANE_STEP = 8'h11;

    // One byte of the test pattern: address, bank seed and lane offset mixed.
    function automatic logic [7:0] lane_byte(input logic [7:0] a8,
                                             input logic [7:0] b8,
                                             input logic [7:0] l8);
        logic [7:0] seed;
        logic [7:0] loff;
        seed = SEED_BASE + SEED_STEP * b8;
        loff = LANE_STEP * l8;
        return a8 ^ seed ^ loff;
    endfunction

endpackage

// File: rtl/mtg_pattern.sv
module mtg_pattern #(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);
    localparam int LANES = DATA_W / 8;

    logic [7:0] a8;
    logic [7:0] b8;

    assign a8 = 8'(addr);
    assign b8 = 8'(bank);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign word[8*i +: 8] = mtg_pkg::lane_byte(a8, b8, 8'(i));
    end
endmodule

// File: rtl/mtg_fifo.sv
module mtg_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R6: a read must never be queued into a full tag store
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
endmodule

// File: rtl/mtg_seq.sv
module mtg_seq #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 4,
    parameter bit LOOP      = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_ready,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              issue_read,
    output logic              test_done
);
    import mtg_pkg::*;

    localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(NUM_BANKS - 1);

    phase_e            ph_q;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr_q;
    step_t             st;

    always_comb begin
        cmd_valid = (ph_q == PH_WRITE) || ((ph_q == PH_READ) && !fifo_full);
        st.fire   = cmd_valid && cmd_ready;
        st.last   = (bank_q == BANK_LAST) && (&addr_q);
    end

    assign cmd_write  = (ph_q == PH_WRITE);
    assign cmd_bank   = bank_q;
    assign cmd_addr   = addr_q;
    assign issue_read = st.fire && (ph_q == PH_READ);
    assign test_done  = (ph_q == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_WRITE;
            bank_q <= '0;
            addr_q <= '0;
        end else begin
            case (ph_q)
                PH_WRITE, PH_READ: begin
                    if (st.fire) begin
                        if (st.last) begin
                            bank_q <= '0;
                            addr_q <= '0;
                            ph_q   <= (ph_q == PH_WRITE) ? PH_READ : PH_DRAIN;
                        end else if (&addr_q) begin
                            addr_q <= '0;
                            bank_q <= bank_q + 1'b1;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                end
                PH_DRAIN: if (fifo_empty) ph_q <= PH_DONE;
                default:  if (LOOP) ph_q <= PH_WRITE;
            endcase
        end
    end

    // R5: a stalled command keeps its fields
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_write)
                                       && $stable(cmd_bank) && $stable(cmd_addr)));

    if (LOOP) begin : g_loop_chk
        // R11: the done indication lasts one cycle when looping
        assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
            test_done |=> (!test_done && cmd_valid && cmd_write));
    end else begin : g_stop_chk
        // R11: a stopped test stays done and quiet
        assert_done_hold_R11: assert property (@(posedge clk) disable iff (rst)
            test_done |=> (test_done && !cmd_valid));
    end
endmodule

// File: rtl/mtg_check.sv
module mtg_check #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] exp_word,
    input  logic              have_tag,
    output logic              pop,
    output logic [DATA_W/8-1:0] lane_pass,
    output logic              all_pass
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] miss;

    assign pop = rd_valid && have_tag;

    for (genvar i = 0; i < LANES; i++) begin : g_cmp
        assign miss[i] = pop && (rd_data[8*i +: 8] != exp_word[8*i +: 8]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_pass <= '1;
            all_pass  <= 1'b1;
        end else begin
            lane_pass <= ~miss;
            all_pass  <= all_pass && !(|miss);
        end
    end

    // R9: once failed, the sticky flag never recovers
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !all_pass |=> !all_pass);

    // R8: no returned data means no failing lane
    assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> (&lane_pass));

    // R9: any failing lane implies the sticky flag is down
    assert_lane_implies_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !(&lane_pass) |-> !all_pass);
endmodule

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester #(
    parameter int NUM_BANKS  = 4,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter bit LOOP       = 1'b0,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int LANES     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic [LANES-1:0]  cmd_be,
    input  logic              cmd_ready,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic [LANES-1:0]  lane_pass,
    output logic              all_pass,
    output logic              test_done
);
    localparam int TAG_W = BANK_W + ADDR_W;

    logic              fifo_full, fifo_empty, issue_read, pop;
    logic [TAG_W-1:0]  head_tag;
    logic [DATA_W-1:0] exp_word;

    mtg_seq #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .LOOP(LOOP)
    ) u_seq (
        .clk(clk), .rst(rst), .cmd_ready(cmd_ready),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .issue_read(issue_read), .test_done(test_done)
    );

    mtg_pattern #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr_pat (
        .bank(cmd_bank), .addr(cmd_addr), .word(cmd_wdata)
    );

    assign cmd_be = cmd_write ? '1 : '0;

    mtg_fifo #(.W(TAG_W), .DEPTH(FIFO_DEPTH)) u_tags (
        .clk(clk), .rst(rst), .push(issue_read), .din({cmd_bank, cmd_addr}),
        .pop(pop), .dout(head_tag), .empty(fifo_empty), .full(fifo_full)
    );

    mtg_pattern #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_pat (
        .bank(head_tag[TAG_W-1 -: BANK_W]), .addr(head_tag[ADDR_W-1:0]),
        .word(exp_word)
    );

    mtg_check #(.DATA_W(DATA_W)) u_chk (
        .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_data(rd_data),
        .exp_word(exp_word), .have_tag(!fifo_empty), .pop(pop),
        .lane_pass(lane_pass), .all_pass(all_pass)
    );

    // R1: the tester leaves reset in its write pass with clean results
    assert_reset_state_R1: assert property (@(posedge clk)
        $fell(rst) |-> (all_pass && (&lane_pass) && !test_done && cmd_write));
endmodule

// File: tb/tb_mem_pattern_tester.sv
module tb_mem_pattern_tester;
    localparam int NB = 4, AW = 4, DW = 32, DEPTH = 4;
    localparam int LOCS = NB * (1 << AW);
    localparam int LN = DW / 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2ns clk = ~clk;

    logic          cmd_valid, cmd_write, all_pass, test_done;
    logic [1:0]    cmd_bank;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;
    logic [LN-1:0] cmd_be, lane_pass;
    logic          cmd_ready = 1'b0, rd_valid = 1'b0;
    logic [DW-1:0] rd_data = '0;

    mem_pattern_tester #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW),
                         .FIFO_DEPTH(DEPTH), .LOOP(1'b0)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_be(cmd_be), .cmd_ready(cmd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .lane_pass(lane_pass), .all_pass(all_pass),
        .test_done(test_done)
    );

    // small looping instance
    logic        l_valid, l_write, l_all, l_done;
    logic        l_bank;
    logic [1:0]  l_addr;
    logic [15:0] l_wdata;
    logic [1:0]  l_be, l_lane;
    logic        l_ready = 1'b1, l_rdv = 1'b0;
    logic [15:0] l_rdata = '0;

    mem_pattern_tester #(.NUM_BANKS(2), .ADDR_W(2), .DATA_W(16),
                         .FIFO_DEPTH(2), .LOOP(1'b1)) dut_loop (
        .clk(clk), .rst(rst), .cmd_valid(l_valid), .cmd_write(l_write),
        .cmd_bank(l_bank), .cmd_addr(l_addr), .cmd_wdata(l_wdata),
        .cmd_be(l_be), .cmd_ready(l_ready), .rd_valid(l_rdv),
        .rd_data(l_rdata), .lane_pass(l_lane), .all_pass(l_all),
        .test_done(l_done)
    );

    int vec = 0, bad = 0;
    bit main_fin = 0, loop_fin = 0, ended = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R3 pattern computed from the requirement
    function automatic logic [63:0] exp_word(input int b, input int a, input int lanes);
        logic [63:0] w = '0;
        for (int i = 0; i < lanes; i++)
            w[8*i +: 8] = 8'(a) ^ 8'(90 + 59 * b) ^ 8'(17 * i);
        return w;
    endfunction

    function automatic logic [3:0] corrupt_mask(input int k);
        case (k)
            10:      return 4'b0001;
            30:      return 4'b1010;
            50:      return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    logic [DW-1:0] mem [LOCS];
    logic [DW-1:0] q_data[$];
    logic [3:0]    q_mask[$];

    initial begin
        int wr_n = 0, rd_n = 0, outst = 0, resp_n = 0, cyc = 0, last_cyc = 0;
        int after_done = 0;
        bit prev_rdv = 0, exp_sticky = 1, prev_stall = 0;
        logic [3:0] prev_mask = '0;
        logic pw;
        logic [1:0] pb;
        logic [AW-1:0] pa;
        logic [DW-1:0] pd;
        void'($urandom(32'h1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(lane_pass == '1 && all_pass && !test_done, "R1 reset", {lane_pass, all_pass, test_done}, 6'b111110);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(lane_pass == '1 && all_pass && !test_done, "R1 after reset", {lane_pass, all_pass, test_done}, 6'b111110);
        chk(cmd_valid && cmd_write && cmd_bank == 0 && cmd_addr == 0, "R2 start",
            {cmd_valid, cmd_write, cmd_bank, cmd_addr}, 8'hC0);
        while (after_done < 20) begin
            // results of the previous edge
            if (prev_rdv) chk(lane_pass == ~prev_mask, "R7 lane result", lane_pass, ~prev_mask);
            else          chk(lane_pass == '1, "R8 idle lanes", lane_pass, 4'hF);
            if (prev_rdv && prev_mask != 0) exp_sticky = 0;
            chk(all_pass == exp_sticky, "R9 sticky", all_pass, exp_sticky);
            chk(test_done == (resp_n == LOCS && cyc >= last_cyc + 2), "R10 done timing",
                test_done, (resp_n == LOCS && cyc >= last_cyc + 2));
            if (test_done) begin
                chk(!cmd_valid, "R11 stopped", cmd_valid, 0);
                after_done++;
            end
            if (prev_stall)
                chk(cmd_valid && cmd_write == pw && cmd_bank == pb && cmd_addr == pa && cmd_wdata == pd,
                    "R5 stall hold", {cmd_valid, cmd_write, cmd_bank, cmd_addr}, {1'b1, pw, pb, pa});
            if (wr_n == LOCS && rd_n < LOCS && outst == DEPTH)
                chk(!cmd_valid, "R6 full stall", cmd_valid, 0);
            // controller model
            cmd_ready = ($urandom_range(0, 9) < 7);
            if (cmd_valid && cmd_ready) begin
                if (wr_n < LOCS) begin
                    chk(cmd_write == 1'b1, "R2 write before reads", cmd_write, 1);
                    chk(cmd_bank == 2'(wr_n / 16) && cmd_addr == AW'(wr_n % 16), "R2 write order",
                        {cmd_bank, cmd_addr}, 6'(wr_n));
                    chk(cmd_be == 4'hF, "R2 byte enables", cmd_be, 4'hF);
                    chk(cmd_wdata == DW'(exp_word(wr_n / 16, wr_n % 16, LN)), "R3 write data",
                        cmd_wdata, exp_word(wr_n / 16, wr_n % 16, LN));
                    mem[{cmd_bank, cmd_addr}] = cmd_wdata;
                    wr_n++;
                end else begin
                    logic [3:0] m;
                    logic [DW-1:0] d;
                    chk(cmd_write == 1'b0 && cmd_be == 4'h0, "R4 read command", {cmd_write, cmd_be}, 0);
                    chk(cmd_bank == 2'(rd_n / 16) && cmd_addr == AW'(rd_n % 16), "R4 read order",
                        {cmd_bank, cmd_addr}, 6'(rd_n));
                    chk(outst < DEPTH, "R6 outstanding", outst, DEPTH - 1);
                    m = corrupt_mask(rd_n);
                    d = mem[{cmd_bank, cmd_addr}];
                    for (int i = 0; i < LN; i++)
                        if (m[i]) d[8*i +: 8] = d[8*i +: 8] ^ 8'($urandom_range(1, 255));
                    q_data.push_back(d);
                    q_mask.push_back(m);
                    rd_n++;
                    outst++;
                end
            end
            prev_stall = cmd_valid && !cmd_ready;
            pw = cmd_write; pb = cmd_bank; pa = cmd_addr; pd = cmd_wdata;
            rd_valid = 1'b0;
            prev_rdv = 0;
            if (q_data.size() > 0 && $urandom_range(0, 9) < 3) begin
                rd_valid = 1'b1;
                rd_data = q_data.pop_front();
                prev_mask = q_mask.pop_front();
                prev_rdv = 1;
                outst--;
                resp_n++;
                if (resp_n == LOCS) last_cyc = cyc;
            end
            cyc++;
            @(negedge clk);
        end
        main_fin = 1;
    end

    initial begin
        int done_seen = 0;
        bit pend = 0, was_done = 0;
        logic [15:0] pdata = '0;
        @(negedge clk);
        while (rst) @(negedge clk);
        @(negedge clk);
        while (done_seen < 2) begin
            if (was_done)
                chk(!l_done && l_valid && l_write && l_bank == 0 && l_addr == 0, "R11 loop restart",
                    {l_done, l_valid, l_write, l_bank, l_addr}, 6'b011000);
            chk(l_all && l_lane == 2'b11, "R7 loop clean data", {l_all, l_lane}, 3'b111);
            was_done = l_done;
            if (l_done) done_seen++;
            l_rdv = pend;
            l_rdata = pdata;
            pend = l_valid && !l_write;
            pdata = 16'(exp_word(int'(l_bank), int'(l_addr), 2));
            @(negedge clk);
        end
        loop_fin = 1;
    end

    initial begin
        fork
            begin
                wait (main_fin && loop_fin);
            end
            begin
                repeat (20000) @(posedge clk);
                bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule